// File: doc/BRIEF.md
# Crosspoint Audio Matrix Mixer

This block forms every output channel of a multichannel audio path as a weighted sum of all input channels. Each input/output pair has its own gain, so any input can be routed to any mix of outputs at its own level. The block is driven by a fast system clock and a one-cycle sample strobe that marks each audio sample boundary. At every strobe it captures all inputs at once, mixes the previous capture, and presents the mix before that on all outputs at once.

Within one sample period a single multiply-accumulate unit visits every crosspoint in turn, grouped by output channel. Gains are written through a shadow copy and take effect only at the next strobe. A single mix therefore never combines old and new gains. Latency from input to output is fixed and independent of the gain settings.

Top module: `xpoint_mixer`

## Requirements
- R1: While reset is high, and after it until the first strobe, every output sample is 0 and `out_valid` is 0.
- R2: Each output o equals the floor of (sum over inputs i of x_i * g(i,o)) / 256, with x_i a signed 16-bit sample and g an unsigned 8-bit gain. A gain of 255 passes a signal at 255/256 of its level and a gain of 0 removes it.
- R3: A mix above 32767 is clamped to 32767 and a mix below -32768 is clamped to -32768, with no wrap-around.
- R4: A gain write with in index i and out index o changes only the crosspoint from input i to output o. Channel n of each flat sample bus occupies bits [16n+15:16n].
- R5: Inputs sampled at strobe k appear on the outputs from the clock edge of strobe k+2, which spans three sample periods: capture, mix and present.
- R6: A gain write is used only by mixes that start at the first strobe after the write. A write in the same cycle as a strobe counts as after that strobe.
- R7: `out_valid` is high for exactly the one cycle after each strobe edge, in which the new output set first appears.
- R8: Outputs hold their value between strobes, whatever the gain writes and input changes.
- R9: The mix of one period completes within NCH*NCH cycles, so strobes spaced at least NCH*NCH+NCH cycles apart never find the engine busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_stb | input | 1 | One-cycle pulse at each audio sample boundary |
| in_flat | input | 256 | 16 signed 16-bit input samples, channel n at [16n+15:16n] |
| gw_en | input | 1 | Gain write enable |
| gw_in_idx | input | 4 | Input channel of the written crosspoint |
| gw_out_idx | input | 4 | Output channel of the written crosspoint |
| gw_gain | input | 8 | Unsigned gain value, 255 near unity |
| out_flat | output | 256 | 16 signed 16-bit output samples, channel n at [16n+15:16n] |
| out_valid | output | 1 | One-cycle pulse when a new output set is presented |

## Verification
On every cycle the assertions check the strobe-to-valid relationship, the width of the valid pulse, that the outputs stay still between updates, and that a strobe never arrives while the engine is still summing. The mix arithmetic, rounding, clamping, crosspoint addressing, the two-strobe latency and the deferred effect of gain writes can only be shown by the bench scenarios. These scenarios compare every presented output set against a reference model of the sum fed with the same samples and gains.

// File: rtl/xm_pkg.sv
package xm_pkg;
  typedef enum logic {ENG_IDLE, ENG_RUN} eng_state_e;

  // smallest strobe spacing in system clocks for a given channel count
  function automatic int min_period(input int nch);
    return nch * nch + nch;
  endfunction
endpackage

// File: rtl/xm_coef_bank.sv
module xm_coef_bank #(
  parameter int NCH = 16,
  parameter int CW  = 8,
  localparam int NXP = NCH * NCH,
  localparam int AW  = $clog2(NXP)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [CW-1:0] wr_data,
  input  logic          swap,
  input  logic [AW-1:0] rd_addr,
  output logic [CW-1:0] rd_data
);
  logic [CW-1:0] shadow [NXP];
  logic [CW-1:0] active [NXP];

  // each crosspoint: shadow takes writes, active takes the shadow at a swap
  for (genvar k = 0; k < NXP; k++) begin : g_xp
    always_ff @(posedge clk) begin
      if (rst) begin
        shadow[k] <= '0;
        active[k] <= '0;
      end else begin
        if (wr_en && wr_addr == AW'(k)) shadow[k] <= wr_data;
        if (swap) active[k] <= shadow[k];
      end
    end
  end

  assign rd_data = active[rd_addr];
endmodule

// File: rtl/xm_mac_engine.sv
module xm_mac_engine
  import xm_pkg::*;
#(
  parameter int NCH  = 16,
  parameter int SW   = 16,
  parameter int CW   = 8,
  parameter int ACCW = 28,
  localparam int LW  = $clog2(NCH),
  localparam int AW  = 2 * LW,
  localparam int PW  = SW + CW + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [NCH*SW-1:0] smp_in,
  output logic [AW-1:0]     coef_addr,
  input  logic [CW-1:0]     coef_in,
  output logic              busy,
  output logic [NCH*SW-1:0] res_flat
);
  eng_state_e state;
  logic [AW-1:0] cnt;
  logic signed [SW-1:0]   work [NCH];
  logic signed [ACCW-1:0] acc;
  logic signed [PW-1:0]   prod;
  logic signed [ACCW-1:0] sum;
  logic signed [ACCW-1:0] shifted;
  logic [SW-1:0]          sat_val;
  logic [LW-1:0]          in_sel, out_sel;
  logic                   last_term;
  logic [SW-1:0]          res [NCH];

  // output-major walk: upper bits pick the output, lower bits the input
  assign in_sel    = cnt[LW-1:0];
  assign out_sel   = cnt[AW-1:LW];
  assign coef_addr = cnt;
  assign busy      = (state == ENG_RUN);
  assign last_term = busy && (in_sel == LW'(NCH - 1));

  assign prod = work[in_sel] * $signed({1'b0, coef_in});
  assign sum  = ((in_sel == '0) ? '0 : acc) + ACCW'(prod);
  assign shifted = sum >>> CW;

  always_comb begin
    if ((&shifted[ACCW-1:SW-1]) || !(|shifted[ACCW-1:SW-1]))
      sat_val = shifted[SW-1:0];
    else if (shifted[ACCW-1])
      sat_val = {1'b1, {(SW-1){1'b0}}};
    else
      sat_val = {1'b0, {(SW-1){1'b1}}};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ENG_IDLE;
      cnt   <= '0;
      acc   <= '0;
      for (int n = 0; n < NCH; n++) work[n] <= '0;
    end else if (start) begin
      state <= ENG_RUN;
      cnt   <= '0;
      for (int n = 0; n < NCH; n++) work[n] <= smp_in[n*SW +: SW];
    end else if (state == ENG_RUN) begin
      acc <= sum;
      cnt <= cnt + 1'b1;
      if (cnt == '1) state <= ENG_IDLE;
    end
  end

  for (genvar o = 0; o < NCH; o++) begin : g_res
    always_ff @(posedge clk) begin
      if (rst) res[o] <= '0;
      else if (last_term && out_sel == LW'(o)) res[o] <= sat_val;
    end
    assign res_flat[o*SW +: SW] = res[o];
  end
endmodule

// File: rtl/xpoint_mixer.sv
module xpoint_mixer #(
  parameter int NCH  = 16,
  parameter int SW   = 16,
  parameter int CW   = 8,
  parameter int ACCW = 28,
  localparam int LW  = $clog2(NCH),
  localparam int AW  = 2 * LW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              smp_stb,
  input  logic [NCH*SW-1:0] in_flat,
  input  logic              gw_en,
  input  logic [LW-1:0]     gw_in_idx,
  input  logic [LW-1:0]     gw_out_idx,
  input  logic [CW-1:0]     gw_gain,
  output logic [NCH*SW-1:0] out_flat,
  output logic              out_valid
);
  logic [NCH*SW-1:0] cap_q;
  logic [NCH*SW-1:0] res_flat;
  logic [AW-1:0]     rd_addr;
  logic [CW-1:0]     rd_gain;
  logic              eng_busy;

  // stage 1: parallel capture at the strobe
  always_ff @(posedge clk) begin
    if (rst) cap_q <= '0;
    else if (smp_stb) cap_q <= in_flat;
  end

  xm_coef_bank #(.NCH(NCH), .CW(CW)) u_bank (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (gw_en),
    .wr_addr ({gw_out_idx, gw_in_idx}),
    .wr_data (gw_gain),
    .swap    (smp_stb),
    .rd_addr (rd_addr),
    .rd_data (rd_gain)
  );

  // stage 2: mix the previous capture during the coming period
  xm_mac_engine #(.NCH(NCH), .SW(SW), .CW(CW), .ACCW(ACCW)) u_mac (
    .clk       (clk),
    .rst       (rst),
    .start     (smp_stb),
    .smp_in    (cap_q),
    .coef_addr (rd_addr),
    .coef_in   (rd_gain),
    .busy      (eng_busy),
    .res_flat  (res_flat)
  );

  // stage 3: parallel release at the strobe
  always_ff @(posedge clk) begin
    if (rst) begin
      out_flat  <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= smp_stb;
      if (smp_stb) out_flat <= res_flat;
    end
  end
endmodule

// File: rtl/xm_checker.sv
module xm_checker #(
  parameter int W = 256
) (
  input logic         clk,
  input logic         rst,
  input logic         smp_stb,
  input logic         out_valid,
  input logic [W-1:0] out_flat,
  input logic         busy
);
  assert_valid_after_stb_R7: assert property (@(posedge clk) disable iff (rst)
    smp_stb |=> out_valid);

  assert_valid_single_R7: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);

  assert_valid_cause_R5: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(smp_stb));

  assert_hold_between_R8: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> $stable(out_flat));

  assert_engine_idle_R9: assert property (@(posedge clk) disable iff (rst)
    smp_stb |-> !busy);
endmodule

bind xpoint_mixer xm_checker #(.W(NCH*SW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .smp_stb   (smp_stb),
  .out_valid (out_valid),
  .out_flat  (out_flat),
  .busy      (eng_busy)
);

// File: tb/xpoint_mixer_test.sv
module xpoint_mixer_test;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 16;
  localparam int SW  = 16;
  localparam int GAP = 290;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic smp_stb = 1'b0;
  logic [NCH*SW-1:0] in_flat = '0;
  logic gw_en = 1'b0;
  logic [3:0] gw_in_idx = '0;
  logic [3:0] gw_out_idx = '0;
  logic [7:0] gw_gain = '0;
  logic [NCH*SW-1:0] out_flat;
  logic out_valid;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  // reference model state
  int shadow_m [NCH][NCH];   // [in][out]
  int cap_m [NCH];
  logic [NCH*SW-1:0] pend_m = '0;
  logic [NCH*SW-1:0] last_seen = '0;
  logic [NCH*SW-1:0] exp_q [$];
  string tag_q [$];
  int xv [NCH];

  always #(CLK_PERIOD/2) clk = ~clk;

  xpoint_mixer uut (
    .clk(clk), .rst(rst), .smp_stb(smp_stb), .in_flat(in_flat),
    .gw_en(gw_en), .gw_in_idx(gw_in_idx), .gw_out_idx(gw_out_idx),
    .gw_gain(gw_gain), .out_flat(out_flat), .out_valid(out_valid)
  );

  function automatic logic [NCH*SW-1:0] mix_model();
    logic [NCH*SW-1:0] r;
    for (int o = 0; o < NCH; o++) begin
      longint acc = 0;
      for (int i = 0; i < NCH; i++) acc += longint'(cap_m[i]) * shadow_m[i][o];
      acc = acc >>> 8;
      if (acc > 32767) acc = 32767;
      if (acc < -32768) acc = -32768;
      r[o*SW +: SW] = 16'(acc);
    end
    return r;
  endfunction

  task automatic wait_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_gain(input int i, input int o, input int g);
    @(negedge clk);
    gw_en = 1'b1; gw_in_idx = 4'(i); gw_out_idx = 4'(o); gw_gain = 8'(g);
    shadow_m[i][o] = g;
    @(negedge clk);
    gw_en = 1'b0;
  endtask

  // driver: one strobe with xv as inputs, optional write in the same cycle
  task automatic strobe(input string tag, input bit with_wr = 0,
                        input int wi = 0, input int wo = 0, input int wg = 0);
    @(negedge clk);
    checks++;
    if (out_flat !== last_seen || out_valid !== 1'b0) begin
      fails++;
      $display("FAIL R8 hold before strobe: out=%h valid=%b expected out=%h valid=0",
               out_flat, out_valid, last_seen);
    end
    for (int n = 0; n < NCH; n++) in_flat[n*SW +: SW] = 16'(xv[n]);
    smp_stb = 1'b1;
    // output presented at this strobe is the pending mix; then mix the capture
    exp_q.push_back(pend_m);
    tag_q.push_back(tag);
    pend_m = mix_model();   // R6: active gains = shadow before any same-cycle write
    for (int n = 0; n < NCH; n++) cap_m[n] = xv[n];
    if (with_wr) begin
      gw_en = 1'b1; gw_in_idx = 4'(wi); gw_out_idx = 4'(wo); gw_gain = 8'(wg);
      shadow_m[wi][wo] = wg;
    end
    @(negedge clk);
    smp_stb = 1'b0;
    gw_en = 1'b0;
  endtask

  // monitor: pops an expected set at each valid pulse (R5 latency, R2 values)
  logic prev_valid = 1'b0;
  always @(negedge clk) begin
    if (!rst) begin
      if (prev_valid && out_valid) begin
        checks++; fails++;
        $display("FAIL R7 valid high two cycles: actual=1 expected=0");
      end
      if (out_valid) begin
        checks++;
        if (exp_q.size() == 0) begin
          fails++;
          $display("FAIL R5 unexpected output set: actual=%h expected=none", out_flat);
        end else begin
          logic [NCH*SW-1:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          if (out_flat !== e) begin
            fails++;
            for (int n = 0; n < NCH; n++)
              if (out_flat[n*SW +: SW] !== e[n*SW +: SW]) begin
                $display("FAIL %s ch %0d: actual=%0d expected=%0d", t, n,
                         $signed(out_flat[n*SW +: SW]), $signed(e[n*SW +: SW]));
                break;
              end
          end
        end
        last_seen = out_flat;
      end
      prev_valid = out_valid;
    end
  end

  task automatic set_pattern(input int seed);
    for (int n = 0; n < NCH; n++) xv[n] = int'($signed(16'((seed + 1) * (n + 3) * 7919)));
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    for (int i = 0; i < NCH; i++) begin
      cap_m[i] = 0; xv[i] = 0;
      for (int o = 0; o < NCH; o++) shadow_m[i][o] = 0;
    end
    wait_cycles(5);
    // R1: reset state
    checks++;
    if (out_flat !== '0 || out_valid !== 1'b0) begin
      fails++;
      $display("FAIL R1 reset: out=%h valid=%b expected 0/0", out_flat, out_valid);
    end
    rst = 1'b0;
    wait_cycles(3);
    checks++;
    if (out_flat !== '0 || out_valid !== 1'b0) begin
      fails++;
      $display("FAIL R1 after reset: out=%h valid=%b expected 0/0", out_flat, out_valid);
    end

    // all gains zero: mixes are zero (R2)
    set_pattern(1); strobe("R2 zero gains"); wait_cycles(GAP);
    // identity routing at 255 (R2, R4)
    for (int n = 0; n < NCH; n++) write_gain(n, n, 255);
    set_pattern(2); strobe("R2 identity"); wait_cycles(GAP);
    set_pattern(3); strobe("R2 identity"); wait_cycles(GAP);
    set_pattern(4); strobe("R5 latency"); wait_cycles(GAP);
    // single off-diagonal crosspoint, input 3 into output 7 (R4)
    write_gain(3, 7, 128);
    set_pattern(5); strobe("R4 crosspoint"); wait_cycles(GAP);
    set_pattern(6); strobe("R4 crosspoint"); wait_cycles(GAP);
    // every input into output 0 at 255, full-scale positive (R3)
    for (int i = 1; i < NCH; i++) write_gain(i, 0, 255);
    for (int n = 0; n < NCH; n++) xv[n] = 32767;
    strobe("R3 clamp high"); wait_cycles(GAP);
    for (int n = 0; n < NCH; n++) xv[n] = -32768;
    strobe("R3 clamp low"); wait_cycles(GAP);
    // mid-period write must wait for the next strobe (R6)
    set_pattern(7); strobe("R6 mid write");
    wait_cycles(100);
    write_gain(5, 5, 17);
    wait_cycles(GAP - 100);
    set_pattern(8); strobe("R6 mid write"); wait_cycles(GAP);
    // write in the strobe cycle itself (R6)
    set_pattern(9); strobe("R6 same-cycle write", 1, 9, 2, 200); wait_cycles(GAP);
    set_pattern(10); strobe("R6 same-cycle write"); wait_cycles(GAP);
    // mixed-sign inputs over a dense gain matrix (R2)
    for (int i = 0; i < NCH; i++) write_gain(i, 12, (i * 37 + 11) % 256);
    set_pattern(11); strobe("R2 dense"); wait_cycles(GAP);
    set_pattern(12); strobe("R2 dense"); wait_cycles(GAP);
    // flush the pipeline so every mix is presented
    set_pattern(13); strobe("R5 flush"); wait_cycles(GAP);
    set_pattern(14); strobe("R5 flush"); wait_cycles(GAP);
    set_pattern(15); strobe("R9 spacing"); wait_cycles(20);
    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R5 missing output sets: actual=%0d expected=0 pending", exp_q.size());
    end
    finished = 1'b1;
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
    end
  end
endmodule